// File: doc/BRIEF.md
# Program Status Register Unit

This unit holds the processor's current status word and one saved-status word for each of the five privileged exception modes (fast interrupt, interrupt, supervisor, abort, undefined). The core uses it to read a status word into a general register and to write one back. A write may target the whole word, or only the condition-flag nibble. It may take its value from a register operand or from a 32-bit immediate, and it may target the current or the saved status.

The unit checks privilege on every write. In user mode only the flag nibble of the current word can change. Saved words can be reached only from a mode that owns one. Reserved bits keep whatever value they hold. A separate exception-entry port is driven by the exception controller. On entry the unit copies the current word into the saved word of the new mode, switches the mode and sets the interrupt masks. This port takes precedence over a software write in the same cycle.

Top module: `psr_unit`

## Requirements
- R1: After reset the current word reads 0x000000D3 (supervisor mode 10011, I bit 7 = 1, F bit 6 = 1, T bit 5 = 0, flags 0), and every saved word reads 0.
- R2: `rdData` is combinational. It shows the current word when `accSaved` is 0, and the saved word of the current mode when `accSaved` is 1 and the current mode is FIQ 10001, IRQ 10010, supervisor 10011, abort 10111 or undefined 11011.
- R3: In a privileged mode, a whole-word register write to the current word loads flags [31:28], I/F/T [7:5] and mode [4:0] from `wrData` on the next clock edge.
- R4: A write with `wrFlagsOnly` = 1 changes only bits [31:28] of its target.
- R5: With `wrUseImm` = 1, only `wrImm[31:28]` is written, and only into the flag nibble, whatever `wrFlagsOnly` is.
- R6: In user mode (10000), a whole-word write to the current word changes only bits [31:28].
- R7: Reserved bits [27:8] of every word keep their stored value, which is 0 from reset, across any write.
- R8: A whole-word write whose mode field is not one of the seven valid encodings (user 10000, system 11111 and the five above) leaves the mode field unchanged and still writes the other fields.
- R9: In user or system mode, a write with `accSaved` = 1 is ignored, and a read with `accSaved` = 1 returns the current word.
- R10: With `excEn` = 1 and `excMode` one of the five exception modes, the next edge copies the current word into that mode's saved word. It also sets mode = `excMode` and I = 1, and sets F = 1 when the mode is FIQ. Flags and T are left as they were. Any other `excMode` is ignored.
- R11: When an exception entry and a software write fall in the same cycle, the write is discarded.
- R12: In a privileged exception mode, a write with `accSaved` = 1 updates only that mode's saved word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accSaved | input | 1 | Target or read the saved word of the current mode |
| wrEn | input | 1 | Software write strobe |
| wrFlagsOnly | input | 1 | Restrict the write to the flag nibble |
| wrUseImm | input | 1 | Take the write value from the immediate |
| wrData | input | 32 | Register operand for writes |
| wrImm | input | 32 | Immediate operand for writes |
| excEn | input | 1 | Exception-entry request |
| excMode | input | 5 | Mode being entered |
| rdData | output | 32 | Read result |
| curStatus | output | 32 | Current status word |

## Verification
Writes are applied in every combination of target (current or saved), width (whole or flags-only) and source (register or immediate). Each is repeated in user, system and exception modes, so that a privilege slip, a wrong field mask or a wrong saved slot each yields a distinct wrong word. Operands carry ones in the reserved bits and invalid mode codes, which separates field masking from mode validation. Exception entries are issued into FIQ and supervisor, with an invalid mode, and together with a write. These show the F-bit rule, the copy into the saved slot and the precedence of entry over a write.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int WORD_W  = 32;
  localparam int MODE_W  = 5;
  localparam int N_SAVED = 5;
  localparam int IDX_W   = $clog2(N_SAVED);
  localparam int FLAG_HI = WORD_W - 1;
  localparam int FLAG_LO = WORD_W - 4;
  localparam int BIT_I   = 7;
  localparam int BIT_F   = 6;
  localparam int BIT_T   = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [WORD_W-1:0] RESET_WORD =
    {{(WORD_W-8){1'b0}}, 1'b1, 1'b1, 1'b0, MODE_SVC};

  typedef struct packed {
    logic             curFlags;
    logic             curCtrl;
    logic             curMode;
    logic             savFlags;
    logic             savCtrl;
    logic             savMode;
    logic             rdSaved;
    logic [IDX_W-1:0] slot;
    logic             excEntry;
    logic [IDX_W-1:0] excSlot;
    logic             excSetF;
    logic             srcImm;
  } psr_strobe_t;

  function automatic logic hasSlot(input logic [MODE_W-1:0] m);
    return (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
           (m == MODE_ABT) || (m == MODE_UND);
  endfunction

  function automatic logic modeValid(input logic [MODE_W-1:0] m);
    return hasSlot(m) || (m == MODE_USR) || (m == MODE_SYS);
  endfunction

  function automatic logic [IDX_W-1:0] slotOf(input logic [MODE_W-1:0] m);
    logic [IDX_W-1:0] idx;
    case (m)
      MODE_FIQ: idx = IDX_W'(0);
      MODE_IRQ: idx = IDX_W'(1);
      MODE_SVC: idx = IDX_W'(2);
      MODE_ABT: idx = IDX_W'(3);
      MODE_UND: idx = IDX_W'(4);
      default:  idx = IDX_W'(0);
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] curMode,
  input  logic              accSaved,
  input  logic              wrEn,
  input  logic              wrFlagsOnly,
  input  logic              wrUseImm,
  input  logic [MODE_W-1:0] srcMode,
  input  logic              excEn,
  input  logic [MODE_W-1:0] excMode,
  output psr_strobe_t       stb
);
  logic privileged;
  logic ownSlot;
  logic excOk;
  logic swWr;
  logic flagsOnly;
  logic srcModeOk;

  always_comb begin
    privileged = (curMode != MODE_USR);
    ownSlot    = hasSlot(curMode);
    excOk      = excEn && hasSlot(excMode);
    swWr       = wrEn && !excOk;
    flagsOnly  = wrFlagsOnly || wrUseImm || !privileged;
    srcModeOk  = modeValid(srcMode);

    stb          = '0;
    stb.srcImm   = wrUseImm;
    stb.slot     = slotOf(curMode);
    stb.rdSaved  = accSaved && ownSlot;
    stb.excEntry = excOk;
    stb.excSlot  = slotOf(excMode);
    stb.excSetF  = (excMode == MODE_FIQ);

    stb.curFlags = swWr && !accSaved;
    stb.curCtrl  = stb.curFlags && !flagsOnly;
    stb.curMode  = stb.curCtrl && srcModeOk;

    stb.savFlags = swWr && accSaved && ownSlot;
    stb.savCtrl  = stb.savFlags && !flagsOnly;
    stb.savMode  = stb.savCtrl && srcModeOk;
  end
endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  psr_strobe_t       stb,
  input  logic [WORD_W-1:0] wrData,
  input  logic [3:0]        immFlags,
  input  logic [MODE_W-1:0] excMode,
  output logic [WORD_W-1:0] curWord,
  output logic [WORD_W-1:0] rdWord
);
  logic [WORD_W-1:0] savWord [N_SAVED];
  logic [3:0]        srcFlags;

  assign srcFlags = stb.srcImm ? immFlags : wrData[FLAG_HI:FLAG_LO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord <= RESET_WORD;
    end else if (stb.excEntry) begin
      curWord[MODE_W-1:0] <= excMode;
      curWord[BIT_I]      <= 1'b1;
      if (stb.excSetF) curWord[BIT_F] <= 1'b1;
    end else begin
      if (stb.curFlags) curWord[FLAG_HI:FLAG_LO] <= srcFlags;
      if (stb.curCtrl)  curWord[BIT_I:BIT_T]     <= wrData[BIT_I:BIT_T];
      if (stb.curMode)  curWord[MODE_W-1:0]      <= wrData[MODE_W-1:0];
    end
  end

  for (genvar g = 0; g < N_SAVED; g++) begin : gSlot
    logic hit;
    assign hit = (stb.slot == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        savWord[g] <= '0;
      end else if (stb.excEntry) begin
        if (stb.excSlot == IDX_W'(g)) savWord[g] <= curWord;
      end else if (hit) begin
        if (stb.savFlags) savWord[g][FLAG_HI:FLAG_LO] <= srcFlags;
        if (stb.savCtrl)  savWord[g][BIT_I:BIT_T]     <= wrData[BIT_I:BIT_T];
        if (stb.savMode)  savWord[g][MODE_W-1:0]      <= wrData[MODE_W-1:0];
      end
    end
  end

  assign rdWord = stb.rdSaved ? savWord[stb.slot] : curWord;
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accSaved,
  input  logic        wrEn,
  input  logic        wrFlagsOnly,
  input  logic        wrUseImm,
  input  logic [31:0] wrData,
  input  logic [31:0] wrImm,
  input  logic        excEn,
  input  logic [4:0]  excMode,
  output logic [31:0] rdData,
  output logic [31:0] curStatus
);
  psr_strobe_t stb;

  psr_ctrl u_ctrl (
    .curMode     (curStatus[MODE_W-1:0]),
    .accSaved    (accSaved),
    .wrEn        (wrEn),
    .wrFlagsOnly (wrFlagsOnly),
    .wrUseImm    (wrUseImm),
    .srcMode     (wrData[MODE_W-1:0]),
    .excEn       (excEn),
    .excMode     (excMode),
    .stb         (stb)
  );

  psr_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .immFlags (wrImm[FLAG_HI:FLAG_LO]),
    .excMode  (excMode),
    .curWord  (curStatus),
    .rdWord   (rdData)
  );
endmodule

// File: rtl/psr_unit_sva.sv
module psr_unit_sva
  import psr_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        accSaved,
  input logic        wrEn,
  input logic        excEn,
  input logic [4:0]  excMode,
  input logic [31:0] rdData,
  input logic [31:0] curStatus
);
  AST_RSV_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    curStatus[27:8] == '0); // R7

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeValid(curStatus[4:0])); // R8

  AST_USER_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && !$past(excEn) && $past(curStatus[4:0]) == MODE_USR)
    |-> curStatus[27:0] == $past(curStatus[27:0])); // R6

  AST_EXC_MODE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(excEn) && hasSlot($past(excMode)))
    |-> (curStatus[4:0] == $past(excMode) && curStatus[BIT_I])); // R10

  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(excEn) && hasSlot($past(excMode)) && $past(wrEn))
    |-> $stable(curStatus[31:28])); // R11

  AST_NO_SLOT_READ: assert property (@(posedge clk) disable iff (!rstN)
    (accSaved && (curStatus[4:0] == MODE_USR || curStatus[4:0] == MODE_SYS))
    |-> rdData == curStatus); // R9
endmodule

bind psr_unit psr_unit_sva u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .accSaved  (accSaved),
  .wrEn      (wrEn),
  .excEn     (excEn),
  .excMode   (excMode),
  .rdData    (rdData),
  .curStatus (curStatus)
);

// File: tb/psr_unit_tb.sv
`timescale 1ns/100ps
module psr_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accSaved = 1'b0, wrEn = 1'b0, wrFlagsOnly = 1'b0, wrUseImm = 1'b0;
  logic [31:0] wrData = '0, wrImm = '0;
  logic        excEn = 1'b0;
  logic [4:0]  excMode = '0;
  logic [31:0] rdData, curStatus;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  psr_unit u_dut (.*);

  typedef struct packed {
    logic        acc, wr, fo, imm;
    logic [31:0] data, immv;
    logic        exc;
    logic [4:0]  em;
    logic [31:0] expCur, expRd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{0,1,0,0,32'h5FFFFF92,32'h0,0,5'h00,32'h50000092,32'h50000092,8'd3},  // R3 R7 whole write, to IRQ
    '{0,1,1,0,32'h3000001F,32'h0,0,5'h00,32'h30000092,32'h30000092,8'd4},  // R4 flags only
    '{0,1,0,1,32'hFFFFFFFF,32'hCFFFFFFF,0,5'h00,32'hC0000092,32'hC0000092,8'd5}, // R5 immediate
    '{1,1,0,0,32'h900000D7,32'h0,0,5'h00,32'hC0000092,32'h900000D7,8'd12}, // R12 saved IRQ write
    '{1,1,1,0,32'h6FFFFFFF,32'h0,0,5'h00,32'hC0000092,32'h600000D7,8'd4},  // R4 saved flags only
    '{0,1,0,0,32'h10000035,32'h0,0,5'h00,32'h10000032,32'h10000032,8'd8},  // R8 invalid mode
    '{0,0,0,0,32'h0,32'h0,1,5'h11,32'h100000F1,32'h100000F1,8'd10},        // R10 FIQ entry
    '{1,0,0,0,32'h0,32'h0,0,5'h00,32'h100000F1,32'h10000032,8'd2},         // R2 read saved FIQ
    '{0,1,0,0,32'hF0000010,32'h0,1,5'h12,32'h100000F2,32'h100000F2,8'd11}, // R11 entry beats write
    '{0,1,0,0,32'h20000010,32'h0,0,5'h00,32'h20000010,32'h20000010,8'd3},  // R3 to user
    '{0,1,0,0,32'h800000D3,32'h0,0,5'h00,32'h80000010,32'h80000010,8'd6},  // R6 user whole write
    '{1,1,0,0,32'h400000D1,32'h0,0,5'h00,32'h80000010,32'h80000010,8'd9},  // R9 user saved write
    '{0,1,0,1,32'h0,32'h70000000,0,5'h00,32'h70000010,32'h70000010,8'd5},  // R5 user immediate
    '{0,0,0,0,32'h0,32'h0,1,5'h10,32'h70000010,32'h70000010,8'd10},        // R10 non-exception mode ignored
    '{0,0,0,0,32'h0,32'h0,1,5'h13,32'h70000093,32'h70000093,8'd10},        // R10 SVC entry, F kept
    '{1,0,0,0,32'h0,32'h0,0,5'h00,32'h70000093,32'h70000010,8'd2},         // R2 read saved SVC
    '{0,1,0,0,32'h0000001F,32'h0,0,5'h00,32'h0000001F,32'h0000001F,8'd3},  // R3 to system
    '{1,1,0,0,32'hF00000D1,32'h0,0,5'h00,32'h0000001F,32'h0000001F,8'd9}   // R9 system saved access
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic checkReset();
    accSaved = 1'b0; #1;
    check("R1 current", curStatus, 32'h000000D3);
    accSaved = 1'b1; #1;
    check("R1 saved SVC", rdData, 32'h00000000);
    accSaved = 1'b0;
  endtask

  initial begin : watchdog
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      accSaved = VECS[i].acc;  wrEn = VECS[i].wr;
      wrFlagsOnly = VECS[i].fo; wrUseImm = VECS[i].imm;
      wrData = VECS[i].data;   wrImm = VECS[i].immv;
      excEn = VECS[i].exc;     excMode = VECS[i].em;
      @(posedge clk);
      @(negedge clk);
      wrEn = 1'b0; excEn = 1'b0;
      #1;
      check($sformatf("R%0d vec%0d cur", VECS[i].req, i), curStatus, VECS[i].expCur);
      check($sformatf("R%0d vec%0d rd", VECS[i].req, i), rdData, VECS[i].expRd);
    end
    // R7: reserved bits stay zero after operands carrying ones there
    check("R7 reserved", curStatus & 32'h0FFFFF00, 32'h0);
    // R1: reset again mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule